// File: doc/BRIEF.md
# Self-Refresh Tick Source Selector

This block produces the stream of refresh requests that keeps a DRAM alive while the rest of the system sleeps. It runs on a fast system clock. It takes one of three timing sources: a slow external refresh strobe whose pulses are active low, a slow external power-down clock, or a count of internal clock cycles. From the chosen source it forms one-cycle refresh ticks at a nominal 64 kHz. That rate covers 256 rows every 4 ms.

A 32 kHz power-down clock with 50% duty can be doubled to 64 kHz by ticking on both of its edges. A slow-interval select divides the 64 kHz stream by eight, for parts that need 256 rows every 32 ms. The block also drives an oscillator enable. The hardware gates the internal oscillators off during suspend only when an external pin paces the refresh. Software can gate them in power-save modes 3 and 4.

The source select and the doubling strap are captured on the first clock edge after reset is released. Both are then held until the next reset.

Top module: `refresh_tick_gen`

## Requirements
- R1: While reset is asserted, and right after it, `tick_o` is 0 and `osc_en_o` is 1.
- R2: With source code 2'b00 (strobe pin), each high-to-low transition of `mref_n_i` gives exactly one `tick_o` pulse that lasts one cycle. The pulse is high after the third rising clock edge that follows the change, because of two synchroniser flops and one output register.
- R3: With source code 2'b01 and the strap at 0, only rising edges of `pdclk_i` give ticks.
- R4: With source code 2'b01 and the strap at 1, both edges of `pdclk_i` give ticks, so a 32 kHz input is doubled.
- R5: With source code 2'b10 or 2'b11 (internal), a tick comes on the INT_DIV-th enabled cycle and then every INT_DIV cycles. The count restarts at zero whenever ticking is disabled.
- R6: When `slow_sel_i` is 1, only every eighth tick is passed on. The divide counter clears whenever `slow_sel_i` changes value or ticking is disabled, so the first divided tick is the eighth tick after that point.
- R7: Ticks are produced only while `sref_en_i` is 1 and either `suspend_i` is 1 or `pwr_mode_i` equals 4. Otherwise source activity is ignored.
- R8: With an external source, `suspend_i` and `sref_en_i` both at 1 drive `osc_en_o` to 0 one cycle later.
- R9: With the internal source, the hardware never clears `osc_en_o`.
- R10: `sw_osc_off_i` clears `osc_en_o` one cycle later only when `pwr_mode_i` is 3 or 4. In other modes it has no effect.
- R11: `src_sel_i` and `dbl_strap_i` are taken on the first clock after reset release. Changes after that have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mref_n_i | input | 1 | External refresh strobe, active-low pulses |
| pdclk_i | input | 1 | External power-down clock |
| src_sel_i | input | 2 | Source: 00 strobe, 01 power-down clock, 1x internal |
| dbl_strap_i | input | 1 | 1: tick on both power-down clock edges |
| slow_sel_i | input | 1 | 1: divide tick stream by eight |
| sref_en_i | input | 1 | Self-refresh option enable |
| suspend_i | input | 1 | Hardware suspend state |
| pwr_mode_i | input | 3 | Software power-save mode number |
| sw_osc_off_i | input | 1 | Software oscillator-off request |
| tick_o | output | 1 | One-cycle refresh request |
| osc_en_o | output | 1 | Internal oscillator enable |

## Verification
The bench replays the same stimulus through a behavioural model and compares both outputs on every cycle. This exposes a synchroniser that is one flop short or one flop long, because every tick would then land a cycle early or late. Changing the select and strap after reset catches a design that reads them live: it would start ticking on the power-down clock. Toggling the slow select briefly in the middle of a count catches a divider that is not cleared: it would emit its tick before the full eight. The internal source is checked with an enable gap and with software gating. A design that gates the oscillators by hardware for that source, or that ignores the mode qualifier on the software bit, shows up on `osc_en_o`.

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int INT_DIV  = 1563,
  parameter int SLOW_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mref_n_i,
  input  logic       pdclk_i,
  input  logic [1:0] src_sel_i,
  input  logic       dbl_strap_i,
  input  logic       slow_sel_i,
  input  logic       sref_en_i,
  input  logic       suspend_i,
  input  logic [2:0] pwr_mode_i,
  input  logic       sw_osc_off_i,
  output logic       tick_o,
  output logic       osc_en_o
);
  localparam int IW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [2:0]    mref_sh, pd_sh;
  logic          cfg_done, dbl_q, slow_q;
  logic [1:0]    src_q;
  logic [IW-1:0] icnt;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mref_sh <= 3'b111;
      pd_sh   <= 3'b000;
    end else begin
      mref_sh <= {mref_sh[1:0], mref_n_i};
      pd_sh   <= {pd_sh[1:0], pdclk_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      src_q    <= 2'b10;
      dbl_q    <= 1'b0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      src_q    <= src_sel_i;
      dbl_q    <= dbl_strap_i;
    end
  end

  wire use_int   = src_q[1];
  wire sw_mode   = (pwr_mode_i == 3'd3) || (pwr_mode_i == 3'd4);
  wire active    = sref_en_i & (suspend_i | (pwr_mode_i == 3'd4));
  wire mref_fall = mref_sh[2] & ~mref_sh[1];
  wire pd_rise   = ~pd_sh[2] & pd_sh[1];
  wire pd_any    = pd_sh[2] ^ pd_sh[1];
  wire ext_edge  = src_q[0] ? (dbl_q ? pd_any : pd_rise) : mref_fall;
  wire int_hit   = (icnt == IW'(INT_DIV - 1));
  wire raw       = active & (use_int ? int_hit : ext_edge);
  wire slow_chg  = slow_sel_i ^ slow_q;
  wire div_hit   = (dcnt == DW'(SLOW_DIV - 1));
  wire hw_off    = suspend_i & sref_en_i & ~use_int;
  wire sw_off    = sw_osc_off_i & sw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt     <= '0;
      dcnt     <= '0;
      slow_q   <= 1'b0;
      tick_o   <= 1'b0;
      osc_en_o <= 1'b1;
    end else begin
      slow_q   <= slow_sel_i;
      tick_o   <= raw & ~slow_chg & (~slow_sel_i | div_hit);
      osc_en_o <= ~(hw_off | sw_off);
      if (!active || !use_int || int_hit) icnt <= '0;
      else                                icnt <= icnt + 1'b1;
      if (!active || slow_chg)  dcnt <= '0;
      else if (raw)             dcnt <= div_hit ? '0 : dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_tick_chk.sv
module refresh_tick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sref_en_i,
  input logic       suspend_i,
  input logic [2:0] pwr_mode_i,
  input logic       sw_osc_off_i,
  input logic       tick_o,
  input logic       osc_en_o,
  input logic       cfg_done,
  input logic [1:0] src_q,
  input logic       dbl_q
);
  wire sw_req = sw_osc_off_i && (pwr_mode_i == 3'd3 || pwr_mode_i == 3'd4);

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sref_en_i |=> !tick_o); // R7
  AST_HW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !src_q[1] && suspend_i && sref_en_i) |=> !osc_en_o); // R8
  AST_INT_NOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && src_q[1] && !sw_req) |=> osc_en_o); // R9
  AST_SW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !osc_en_o); // R10
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> ($stable(src_q) && $stable(dbl_q))); // R11
endmodule

bind refresh_tick_gen refresh_tick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sref_en_i(sref_en_i), .suspend_i(suspend_i),
  .pwr_mode_i(pwr_mode_i), .sw_osc_off_i(sw_osc_off_i), .tick_o(tick_o),
  .osc_en_o(osc_en_o), .cfg_done(cfg_done), .src_q(src_q), .dbl_q(dbl_q)
);

// File: tb/refresh_tick_gen_tb.sv
module refresh_tick_gen_tb;
  localparam int IDIV = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mref_n = 1'b1, pdclk = 1'b0, dbl = 1'b0, slow = 1'b0;
  logic sref = 1'b0, susp = 1'b0, swoff = 1'b0;
  logic [1:0] src = 2'b00;
  logic [2:0] mode = 3'd0;
  logic tick_o, osc_en_o;

  int checks = 0, errs = 0, tick_cnt = 0;
  string cur_req = "R1";

  refresh_tick_gen #(.INT_DIV(IDIV), .SLOW_DIV(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mref_n_i(mref_n), .pdclk_i(pdclk),
    .src_sel_i(src), .dbl_strap_i(dbl), .slow_sel_i(slow), .sref_en_i(sref),
    .suspend_i(susp), .pwr_mode_i(mode), .sw_osc_off_i(swoff),
    .tick_o(tick_o), .osc_en_o(osc_en_o));

  always #5 clk = ~clk;

  logic [3:0] hm = 4'b1111, hp = 4'b0000;
  logic [1:0] m_src = 2'b10;
  logic m_dbl = 1'b0, m_done = 1'b0, slow_q = 1'b0;
  int icnt = 0, dcnt = 0;
  logic exp_tick = 1'b0, exp_osc = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      hm = 4'b1111; hp = 4'b0000; m_src = 2'b10; m_dbl = 1'b0; m_done = 1'b0;
      slow_q = 1'b0; icnt = 0; dcnt = 0; exp_tick = 1'b0; exp_osc = 1'b1;
    end else begin
      logic act, raw, chg;
      hm = {hm[2:0], mref_n};
      hp = {hp[2:0], pdclk};
      act = sref && (susp || mode == 3'd4);
      if (m_src[1])      raw = act && (icnt == IDIV - 1);
      else if (m_src[0]) raw = act && (m_dbl ? (hp[2] != hp[3]) : (hp[2] && !hp[3]));
      else               raw = act && hm[3] && !hm[2];
      chg = (slow != slow_q);
      exp_tick = raw && !chg && (!slow || dcnt == 7);
      exp_osc = !((susp && sref && !m_src[1]) || (swoff && (mode == 3'd3 || mode == 3'd4)));
      if (!act || !m_src[1]) icnt = 0; else icnt = (icnt == IDIV - 1) ? 0 : icnt + 1;
      if (!act || chg) dcnt = 0; else if (raw) dcnt = (dcnt + 1) % 8;
      slow_q = slow;
      if (!m_done) begin m_src = src; m_dbl = dbl; m_done = 1'b1; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(tick_o === exp_tick, {cur_req, " tick_o"}, tick_o, exp_tick);
    chk(osc_en_o === exp_osc, {cur_req, " osc_en_o"}, osc_en_o, exp_osc);
    if (tick_o === 1'b1) tick_cnt++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s, input logic d);
    @(negedge clk);
    rst_n = 1'b0; src = s; dbl = d; sref = 0; susp = 0; slow = 0; swoff = 0; mode = 0;
    mref_n = 1'b1; pdclk = 1'b0;
    wait_cyc(3);
    chk(tick_o == 1'b0 && osc_en_o == 1'b1, "R1 reset outputs", {tick_o, osc_en_o}, 2'b01);
    rst_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic mref_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      mref_n = 1'b0; wait_cyc(2); mref_n = 1'b1; wait_cyc(6);
    end
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    chk(tick_o == 1'b0 && osc_en_o == 1'b1, "R1 initial reset", {tick_o, osc_en_o}, 2'b01);

    do_reset(2'b00, 1'b0);
    sref = 1; susp = 1; wait_cyc(2);
    cur_req = "R8"; chk(osc_en_o == 1'b0, "R8 hw gate on pin source", osc_en_o, 0);
    cur_req = "R2"; tick_cnt = 0; mref_pulses(5);
    chk(tick_cnt == 5, "R2 strobe tick count", tick_cnt, 5);

    cur_req = "R11"; src = 2'b01; dbl = 1'b1; tick_cnt = 0;
    for (int i = 0; i < 6; i++) begin pdclk = ~pdclk; wait_cyc(5); end
    wait_cyc(4);
    chk(tick_cnt == 0, "R11 late select ignored", tick_cnt, 0);
    mref_pulses(3);
    chk(tick_cnt == 3, "R11 strobe still source", tick_cnt, 3);

    cur_req = "R6"; slow = 1; wait_cyc(2); tick_cnt = 0; mref_pulses(16);
    chk(tick_cnt == 2, "R6 divide by eight", tick_cnt, 2);
    mref_pulses(5);
    slow = 0; wait_cyc(1); slow = 1; wait_cyc(2);
    tick_cnt = 0; mref_pulses(7);
    chk(tick_cnt == 0, "R6 counter cleared on change", tick_cnt, 0);
    mref_pulses(1);
    chk(tick_cnt == 1, "R6 first tick after full period", tick_cnt, 1);
    slow = 0; wait_cyc(2);

    cur_req = "R7"; sref = 0; tick_cnt = 0; mref_pulses(3);
    chk(tick_cnt == 0, "R7 no ticks without self-refresh", tick_cnt, 0);
    sref = 1; susp = 0; mode = 3'd4; mref_pulses(3);
    chk(tick_cnt == 3, "R7 mode 4 ticks", tick_cnt, 3);
    mode = 3'd3; mref_pulses(3);
    chk(tick_cnt == 3, "R7 mode 3 no ticks", tick_cnt, 3);

    do_reset(2'b01, 1'b0);
    cur_req = "R3"; sref = 1; susp = 1; wait_cyc(2); tick_cnt = 0;
    for (int i = 0; i < 4; i++) begin pdclk = 1; wait_cyc(2); pdclk = 0; wait_cyc(6); end
    wait_cyc(4);
    chk(tick_cnt == 4, "R3 rising edges only", tick_cnt, 4);

    do_reset(2'b01, 1'b1);
    cur_req = "R4"; sref = 1; susp = 1; wait_cyc(2); tick_cnt = 0;
    for (int i = 0; i < 6; i++) begin pdclk = ~pdclk; wait_cyc(8); end
    chk(tick_cnt == 6, "R4 both edges", tick_cnt, 6);

    do_reset(2'b10, 1'b0);
    cur_req = "R5"; tick_cnt = 0; sref = 1; susp = 1;
    wait_cyc(205);
    chk(tick_cnt == 10, "R5 internal period", tick_cnt, 10);
    cur_req = "R9"; chk(osc_en_o == 1'b1, "R9 internal never hw gated", osc_en_o, 1);
    cur_req = "R5"; sref = 0; wait_cyc(3); sref = 1; tick_cnt = 0; wait_cyc(15);
    chk(tick_cnt == 0, "R5 count restarts", tick_cnt, 0);
    cur_req = "R10"; mode = 3'd3; swoff = 1; wait_cyc(2);
    chk(osc_en_o == 1'b0, "R10 sw gate in mode 3", osc_en_o, 0);
    mode = 3'd2; wait_cyc(2);
    chk(osc_en_o == 1'b1, "R10 sw bit ignored in mode 2", osc_en_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule